// File: doc/BRIEF.md
# CRT Character Timing Generator

This block produces the raster timing for a character-cell display and tells the rest of the video path which display-memory word is on screen and which scan line of the glyph is being drawn. It runs on the character clock. It steps a character counter across each line, a scan counter down each character row, and a row counter down the frame. After the last character row it can add a few extra scan lines before the frame starts again. From these counters and a set of programmable timing values it drives horizontal sync, vertical sync, display enable and a cursor strobe.

The timing values arrive as plain input buses. The block copies them into a shadow set when it comes out of reset and on the last character of every frame. Software can therefore rewrite them at any time without tearing a line or a frame. Fetching glyphs, shifting pixels, decoding attributes and arbitrating memory belong to other blocks.

Top module: `crtc_timing`

## Requirements
- R1: A line lasts `h_total`+1 character clocks. Within a line `ma` rises by one on every character clock.
- R2: `hsync` is high on character positions `c` where `hs_pos` <= `c` < `hs_pos`+`hs_width`, with no wrap into the next line. A width of 0 gives no horizontal sync.
- R3: A character row has `scan_max`+1 scan lines, and `ra` counts 0 to `scan_max` within it. The frame has `v_total`+1 rows. These are followed by `v_adjust` extra lines, on which `ra` counts 0 to `v_adjust`-1. The frame then wraps to row 0, line 0. When `v_adjust` is 0 there are no extra lines.
- R4: `de` is high when all three hold: the character position is below `h_disp`, the row is below `v_disp`, and the line is not one of the extra lines.
- R5: `vsync` rises at the first scan line of row `vs_pos` and stays high for exactly 16 scan lines, continuing across a frame wrap if needed.
- R6: A frame starts at `start_addr`. Each scan line restarts at its row's base address. The base advances by `h_disp` after the last scan line of each row, so the extra lines use the base that follows the final row. Addresses wrap modulo 2^14.
- R7: `cursor` is high when all three hold: `de` is high, `ma` equals `cur_addr`, and `cur_first` <= `ra` <= `cur_last`. If `cur_first` > `cur_last` the cursor never shows.
- R8: Timing inputs are sampled only during reset and on the last character clock of a frame. A change at any other time has no effect until the next frame begins.
- R9: While `rst` is high, all counters are held at zero and `ma` equals `start_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst | input | 1 | Synchronous reset, active high |
| h_total | input | 8 | Characters per line minus one |
| h_disp | input | 8 | Displayed characters per line |
| hs_pos | input | 8 | Character position where horizontal sync starts |
| hs_width | input | 4 | Horizontal sync width in characters |
| v_total | input | 7 | Character rows per frame minus one |
| v_adjust | input | 5 | Extra scan lines after the last row |
| v_disp | input | 7 | Displayed character rows |
| vs_pos | input | 7 | Row where vertical sync starts |
| scan_max | input | 5 | Scan lines per row minus one |
| cur_first | input | 5 | First scan line of the cursor |
| cur_last | input | 5 | Last scan line of the cursor |
| start_addr | input | 14 | Address of the top-left character |
| cur_addr | input | 14 | Address of the cursor cell |
| ma | output | 14 | Display-memory address of the current cell |
| ra | output | 5 | Scan line within the current row |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Display enable |
| cursor | output | 1 | Cursor strobe |

## Verification
The bench builds the block with its default vertical sync length of 16 lines and the default bus widths. It programs deliberately small timing sets, a few hundred character clocks per frame, so that several whole frames fit in one run. These small frames make it possible to see a 16-line vertical sync that is longer than the distance to the frame wrap and so spills into the next frame. They also cover a frame with no extra lines, a start address that wraps past 2^14 inside the visible area, a zero-width horizontal sync, and an inverted cursor window. A further timing set is switched in mid-frame, so that the bench sees the old values hold until the frame boundary and the new ones take over on the next character.

// File: rtl/crtc_pkg.sv
`timescale 1ns/1ps
package crtc_pkg;
  localparam int CHW  = 8;   // character counter width
  localparam int ROWW = 7;   // row counter width
  localparam int SCW  = 5;   // scan line counter width
  localparam int HSW  = 4;   // horizontal sync width field
  localparam int MAW  = 14;  // memory address width

  typedef struct packed {
    logic [CHW-1:0]  h_total;
    logic [CHW-1:0]  h_disp;
    logic [CHW-1:0]  hs_pos;
    logic [HSW-1:0]  hs_width;
    logic [ROWW-1:0] v_total;
    logic [ROWW-1:0] v_disp;
    logic [ROWW-1:0] vs_pos;
    logic [SCW-1:0]  v_adjust;
    logic [SCW-1:0]  scan_max;
    logic [SCW-1:0]  cur_first;
    logic [SCW-1:0]  cur_last;
    logic [MAW-1:0]  cur_addr;
  } crtc_cfg_t;

  // true when pos lies in [first, first+len), computed one bit wider
  function automatic logic in_span(input logic [CHW-1:0] pos,
                                   input logic [CHW-1:0] first,
                                   input logic [HSW-1:0] len);
    logic [CHW:0] lim;
    lim = {1'b0, first} + (CHW+1)'(len);
    return ({1'b0, pos} >= {1'b0, first}) && ({1'b0, pos} < lim);
  endfunction

  // base address of the following character row
  function automatic logic [MAW-1:0] next_row_base(input logic [MAW-1:0] base,
                                                   input logic [CHW-1:0] disp);
    return base + MAW'(disp);
  endfunction

  function automatic logic cursor_hit(input logic de, input logic [MAW-1:0] ma,
                                      input logic [MAW-1:0] at,
                                      input logic [SCW-1:0] line,
                                      input logic [SCW-1:0] first,
                                      input logic [SCW-1:0] last);
    return de && (ma == at) && (line >= first) && (line <= last);
  endfunction
endpackage

// File: rtl/crtc_shadow.sv
`timescale 1ns/1ps
module crtc_shadow
  import crtc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      frame_end,
  input  crtc_cfg_t cfg_in,
  output crtc_cfg_t cfg_q
);
  logic load;
  assign load = rst | frame_end;

  always_ff @(posedge clk) begin
    if (load) cfg_q <= cfg_in;
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !frame_end |=> (cfg_q == $past(cfg_q))); // R8
endmodule

// File: rtl/crtc_hctr.sv
`timescale 1ns/1ps
module crtc_hctr
  import crtc_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic [CHW-1:0] h_total,
  input  logic [CHW-1:0] h_disp,
  input  logic [CHW-1:0] hs_pos,
  input  logic [HSW-1:0] hs_width,
  output logic           line_end,
  output logic           h_de,
  output logic           hsync
);
  logic [CHW-1:0] hc;

  assign line_end = (hc == h_total);
  assign h_de     = (hc < h_disp);
  assign hsync    = in_span(hc, hs_pos, hs_width);

  always_ff @(posedge clk) begin
    if (rst)           hc <= '0;
    else if (line_end) hc <= '0;
    else               hc <= hc + CHW'(1);
  end

  AST_LINE_WRAP: assert property (@(posedge clk) disable iff (rst)
    line_end |=> (hc == '0)); // R1
  AST_HC_STEP: assert property (@(posedge clk) disable iff (rst)
    !line_end |=> (hc == $past(hc) + CHW'(1))); // R1
  AST_HS_NONE: assert property (@(posedge clk) disable iff (rst)
    (hs_width == '0) |-> !hsync); // R2
endmodule

// File: rtl/crtc_vctr.sv
`timescale 1ns/1ps
module crtc_vctr
  import crtc_pkg::*;
#(
  parameter int VS_LINES = 16
)(
  input  logic            clk,
  input  logic            rst,
  input  logic            line_end,
  input  logic [ROWW-1:0] v_total,
  input  logic [ROWW-1:0] v_disp,
  input  logic [ROWW-1:0] vs_pos,
  input  logic [SCW-1:0]  v_adjust,
  input  logic [SCW-1:0]  scan_max,
  output logic [SCW-1:0]  scan,
  output logic            row_last,
  output logic            frame_end,
  output logic            v_de,
  output logic            vsync
);
  localparam int VSCW = $clog2(VS_LINES + 1);

  logic [ROWW-1:0] row, nxt_row;
  logic [SCW-1:0]  nxt_scan;
  logic            in_adj, nxt_adj;
  logic [VSCW-1:0] vs_left;
  logic            last_row, adj_last, vs_start;

  assign row_last  = !in_adj && (scan == scan_max);
  assign last_row  = (row == v_total);
  assign adj_last  = in_adj && (scan == v_adjust - SCW'(1));
  assign frame_end = line_end && (adj_last || (row_last && last_row && (v_adjust == '0)));

  // position of the next scan line
  always_comb begin
    nxt_row  = row;
    nxt_scan = scan + SCW'(1);
    nxt_adj  = in_adj;
    if (in_adj) begin
      if (adj_last) begin
        nxt_row  = '0;
        nxt_scan = '0;
        nxt_adj  = 1'b0;
      end
    end else if (row_last) begin
      nxt_scan = '0;
      if (last_row) begin
        if (v_adjust == '0) nxt_row = '0;
        else                nxt_adj = 1'b1;
      end else begin
        nxt_row = row + ROWW'(1);
      end
    end
  end

  assign vs_start = !nxt_adj && (nxt_scan == '0) && (nxt_row == vs_pos);

  always_ff @(posedge clk) begin
    if (rst) begin
      row     <= '0;
      scan    <= '0;
      in_adj  <= 1'b0;
      vs_left <= '0;
    end else if (line_end) begin
      row    <= nxt_row;
      scan   <= nxt_scan;
      in_adj <= nxt_adj;
      if (vs_start)            vs_left <= VSCW'(VS_LINES);
      else if (vs_left != '0)  vs_left <= vs_left - VSCW'(1);
    end
  end

  assign vsync = (vs_left != '0);
  assign v_de  = !in_adj && (row < v_disp);

  AST_SCAN_LIMIT: assert property (@(posedge clk) disable iff (rst)
    !in_adj |-> (scan <= scan_max)); // R3
  AST_ADJ_LIMIT: assert property (@(posedge clk) disable iff (rst)
    in_adj |-> (scan < v_adjust)); // R3
  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> (row == '0 && scan == '0 && !in_adj)); // R3
  AST_VS_ON_LINE: assert property (@(posedge clk) disable iff (rst)
    $rose(vsync) |-> $past(line_end)); // R5
  AST_VS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (vsync && !line_end) |=> vsync); // R5
endmodule

// File: rtl/crtc_addr.sv
`timescale 1ns/1ps
module crtc_addr
  import crtc_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic [MAW-1:0] start_addr,
  input  logic [CHW-1:0] h_disp,
  input  logic [MAW-1:0] cur_addr,
  input  logic [SCW-1:0] cur_first,
  input  logic [SCW-1:0] cur_last,
  input  logic           line_end,
  input  logic           row_last,
  input  logic           frame_end,
  input  logic           h_de,
  input  logic           v_de,
  input  logic [SCW-1:0] ra,
  output logic [MAW-1:0] ma,
  output logic           de,
  output logic           cursor
);
  logic [MAW-1:0] row_base, base_nxt;

  assign base_nxt = next_row_base(row_base, h_disp);

  always_ff @(posedge clk) begin
    if (rst || frame_end) begin
      row_base <= start_addr;
      ma       <= start_addr;
    end else if (line_end) begin
      if (row_last) begin
        row_base <= base_nxt;
        ma       <= base_nxt;
      end else begin
        ma <= row_base;
      end
    end else begin
      ma <= ma + MAW'(1);
    end
  end

  assign de     = h_de && v_de;
  assign cursor = cursor_hit(de, ma, cur_addr, ra, cur_first, cur_last);

  AST_MA_STEP: assert property (@(posedge clk) disable iff (rst)
    !line_end |=> (ma == $past(ma) + MAW'(1))); // R6
  AST_MA_FRAME: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> (ma == $past(start_addr))); // R6
  AST_CURSOR_IN_DE: assert property (@(posedge clk) disable iff (rst)
    cursor |-> de); // R7
endmodule

// File: rtl/crtc_timing.sv
`timescale 1ns/1ps
module crtc_timing
  import crtc_pkg::*;
#(
  parameter int VS_LINES = 16
)(
  input  logic            clk,
  input  logic            rst,
  input  logic [CHW-1:0]  h_total,
  input  logic [CHW-1:0]  h_disp,
  input  logic [CHW-1:0]  hs_pos,
  input  logic [HSW-1:0]  hs_width,
  input  logic [ROWW-1:0] v_total,
  input  logic [SCW-1:0]  v_adjust,
  input  logic [ROWW-1:0] v_disp,
  input  logic [ROWW-1:0] vs_pos,
  input  logic [SCW-1:0]  scan_max,
  input  logic [SCW-1:0]  cur_first,
  input  logic [SCW-1:0]  cur_last,
  input  logic [MAW-1:0]  start_addr,
  input  logic [MAW-1:0]  cur_addr,
  output logic [MAW-1:0]  ma,
  output logic [SCW-1:0]  ra,
  output logic            hsync,
  output logic            vsync,
  output logic            de,
  output logic            cursor
);
  crtc_cfg_t cfg_in, cfg;
  logic line_end, row_last, frame_end, h_de, v_de;

  always_comb begin
    cfg_in.h_total   = h_total;
    cfg_in.h_disp    = h_disp;
    cfg_in.hs_pos    = hs_pos;
    cfg_in.hs_width  = hs_width;
    cfg_in.v_total   = v_total;
    cfg_in.v_disp    = v_disp;
    cfg_in.vs_pos    = vs_pos;
    cfg_in.v_adjust  = v_adjust;
    cfg_in.scan_max  = scan_max;
    cfg_in.cur_first = cur_first;
    cfg_in.cur_last  = cur_last;
    cfg_in.cur_addr  = cur_addr;
  end

  crtc_shadow u_shadow (
    .clk(clk), .rst(rst), .frame_end(frame_end), .cfg_in(cfg_in), .cfg_q(cfg)
  );

  crtc_hctr u_hctr (
    .clk(clk), .rst(rst), .h_total(cfg.h_total), .h_disp(cfg.h_disp),
    .hs_pos(cfg.hs_pos), .hs_width(cfg.hs_width),
    .line_end(line_end), .h_de(h_de), .hsync(hsync)
  );

  crtc_vctr #(.VS_LINES(VS_LINES)) u_vctr (
    .clk(clk), .rst(rst), .line_end(line_end), .v_total(cfg.v_total),
    .v_disp(cfg.v_disp), .vs_pos(cfg.vs_pos), .v_adjust(cfg.v_adjust),
    .scan_max(cfg.scan_max), .scan(ra), .row_last(row_last),
    .frame_end(frame_end), .v_de(v_de), .vsync(vsync)
  );

  crtc_addr u_addr (
    .clk(clk), .rst(rst), .start_addr(start_addr), .h_disp(cfg.h_disp),
    .cur_addr(cfg.cur_addr), .cur_first(cfg.cur_first), .cur_last(cfg.cur_last),
    .line_end(line_end), .row_last(row_last), .frame_end(frame_end),
    .h_de(h_de), .v_de(v_de), .ra(ra), .ma(ma), .de(de), .cursor(cursor)
  );

  AST_RESET_ADDR: assert property (@(posedge clk)
    rst |=> (ra == '0)); // R9
endmodule

// File: tb/sim_crtc_timing.sv
`timescale 1ns/1ps
module sim_crtc_timing;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0]  i_ht, i_hd, i_hp;
  logic [3:0]  i_hw;
  logic [6:0]  i_vt, i_vd, i_vp;
  logic [4:0]  i_va, i_ms, i_cs, i_ce;
  logic [13:0] i_sa, i_ca;
  logic [13:0] ma;
  logic [4:0]  ra;
  logic        hsync, vsync, de, cursor;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // configuration staged for the inputs (c_) and the one the model follows (m_)
  int c_ht, c_hd, c_hp, c_hw, c_vt, c_va, c_vd, c_vp, c_ms, c_cs, c_ce, c_sa, c_ca;
  int m_ht, m_hd, m_hp, m_hw, m_vt, m_va, m_vd, m_vp, m_ms, m_cs, m_ce, m_sa, m_ca;

  always #4 clk = ~clk;

  crtc_timing u0 (
    .clk(clk), .rst(rst), .h_total(i_ht), .h_disp(i_hd), .hs_pos(i_hp),
    .hs_width(i_hw), .v_total(i_vt), .v_adjust(i_va), .v_disp(i_vd),
    .vs_pos(i_vp), .scan_max(i_ms), .cur_first(i_cs), .cur_last(i_ce),
    .start_addr(i_sa), .cur_addr(i_ca), .ma(ma), .ra(ra), .hsync(hsync),
    .vsync(vsync), .de(de), .cursor(cursor)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cfg_set(input int ht, hd, hp, hw, vt, va, vd, vp, ms, cs, ce, sa, ca);
    c_ht = ht; c_hd = hd; c_hp = hp; c_hw = hw; c_vt = vt; c_va = va; c_vd = vd;
    c_vp = vp; c_ms = ms; c_cs = cs; c_ce = ce; c_sa = sa; c_ca = ca;
  endtask

  task automatic apply_inputs();
    i_ht = 8'(c_ht); i_hd = 8'(c_hd); i_hp = 8'(c_hp); i_hw = 4'(c_hw);
    i_vt = 7'(c_vt); i_va = 5'(c_va); i_vd = 7'(c_vd); i_vp = 7'(c_vp);
    i_ms = 5'(c_ms); i_cs = 5'(c_cs); i_ce = 5'(c_ce);
    i_sa = 14'(c_sa); i_ca = 14'(c_ca);
  endtask

  task automatic adopt_model();
    m_ht = c_ht; m_hd = c_hd; m_hp = c_hp; m_hw = c_hw; m_vt = c_vt; m_va = c_va;
    m_vd = c_vd; m_vp = c_vp; m_ms = c_ms; m_cs = c_cs; m_ce = c_ce; m_sa = c_sa;
    m_ca = c_ca;
  endtask

  // expected outputs t character clocks after the frame began
  task automatic compare_at(input int t);
    int hlen, rlen, act_lines, flen, c, g, l, row, sc, d, e_ma;
    bit adj, e_de, e_hs, e_vs, e_cur;
    hlen = m_ht + 1;
    rlen = m_ms + 1;
    act_lines = (m_vt + 1) * rlen;
    flen = act_lines + m_va;
    c = t % hlen;
    g = t / hlen;
    l = g % flen;
    if (l < act_lines) begin
      adj = 0; row = l / rlen; sc = l % rlen;
    end else begin
      adj = 1; row = m_vt + 1; sc = l - act_lines;
    end
    e_ma  = (m_sa + row * m_hd + c) % 16384;
    e_de  = (c < m_hd) && !adj && (row < m_vd);
    e_hs  = (c >= m_hp) && (c < m_hp + m_hw);
    d     = g - m_vp * rlen;
    e_vs  = (d >= 0) && ((d % flen) < 16);
    e_cur = e_de && (e_ma == m_ca) && (sc >= m_cs) && (sc <= m_ce);
    chk("R1 R6", "ma", int'(ma), e_ma);
    chk("R3", "ra", int'(ra), sc);
    chk("R2", "hsync", int'(hsync), int'(e_hs));
    chk("R4", "de", int'(de), int'(e_de));
    chk("R5", "vsync", int'(vsync), int'(e_vs));
    chk("R7", "cursor", int'(cursor), int'(e_cur));
  endtask

  task automatic run_span(input int n, inout int t);
    for (int i = 0; i < n; i++) begin
      compare_at(t);
      t++;
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  function automatic int frame_cycles();
    return (m_ht + 1) * ((m_vt + 1) * (m_ms + 1) + m_va);
  endfunction

  // R9: state while reset is held
  task automatic t_reset_state();
    cfg_set(9, 6, 7, 2, 6, 2, 4, 2, 3, 1, 2, 'h100, 'h10F);
    apply_inputs(); adopt_model();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9", "ma in reset", int'(ma), 'h100);
    chk("R9", "ra in reset", int'(ra), 0);
    chk("R9", "hsync in reset", int'(hsync), 0);
    chk("R9", "vsync in reset", int'(vsync), 0);
    chk("R9", "de in reset", int'(de), 1);
    chk("R9", "cursor in reset", int'(cursor), 0);
  endtask

  // R1..R7: two full frames with extra lines and a visible cursor
  task automatic t_base_frames();
    int t = 0;
    cfg_set(9, 6, 7, 2, 6, 2, 4, 2, 3, 1, 2, 'h100, 'h10F);
    apply_inputs(); adopt_model(); do_reset();
    run_span(2 * frame_cycles(), t);
  endtask

  // R5: a 16-line vertical sync that runs past the frame wrap; R3 adjust lines
  task automatic t_vsync_wrap();
    int t = 0;
    cfg_set(5, 4, 4, 1, 5, 1, 5, 4, 1, 1, 1, 'h40, 'h4D);
    apply_inputs(); adopt_model(); do_reset();
    run_span(4 * frame_cycles(), t);
  endtask

  // R3 no extra lines, R2 zero-width sync, R7 inverted cursor window
  task automatic t_no_adjust();
    int t = 0;
    cfg_set(7, 5, 6, 0, 3, 0, 4, 3, 2, 2, 1, 0, 5);
    apply_inputs(); adopt_model(); do_reset();
    run_span(2 * frame_cycles(), t);
  endtask

  // R6: start address wraps past 2^14 inside the visible area
  task automatic t_addr_wrap();
    int t = 0;
    cfg_set(9, 6, 7, 2, 3, 1, 3, 1, 1, 0, 1, 'h3FFA, 'h0002);
    apply_inputs(); adopt_model(); do_reset();
    run_span(2 * frame_cycles(), t);
  endtask

  // R8: new values written mid-frame wait for the frame boundary
  task automatic t_reload();
    int t = 0;
    int first_len;
    cfg_set(9, 6, 7, 2, 6, 2, 4, 2, 3, 1, 2, 'h100, 'h10F);
    apply_inputs(); adopt_model(); do_reset();
    first_len = frame_cycles();
    run_span(137, t);
    cfg_set(7, 5, 5, 3, 4, 1, 3, 1, 2, 0, 2, 'h200, 'h206);
    apply_inputs();
    run_span(first_len - 137, t);   // model keeps the old set: R8
    adopt_model();
    t = 0;
    run_span(2 * frame_cycles(), t);
  endtask

  initial begin
    cfg_set(9, 6, 7, 2, 6, 2, 4, 2, 3, 1, 2, 'h100, 'h10F);
    apply_inputs();
    @(negedge clk);
    t_reset_state();
    t_base_frames();
    t_vsync_wrap();
    t_no_adjust();
    t_addr_wrap();
    t_reload();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule